// File: doc/BRIEF.md
# Host Buffer Memory Access Port

This block gives a host a narrow window into a packet buffer SRAM, such as the receive buffer of a network controller. The host sends commands on a valid/ready stream. Some commands load a 16-bit byte read pointer one byte at a time. One reads data and moves the pointer forward. One peeks at the data without moving the pointer. One stores data at a separately held write address and leaves that address where it was. A separate plain pin gives the host bus width: 8, 16 or 32 bits. The width sets both which byte lanes of the 32-bit SRAM word are used and how far a read moves the pointer.

The block keeps one SRAM word for the current read pointer in a prefetch register, so a read is answered from that register in a single cycle. After any command that moves the pointer or may change the memory, the register is dropped and loaded again. The SRAM has a fixed one-cycle read latency, so the reload takes two cycles, and during those cycles no command is accepted.

Two rules decide where the pointer wraps, chosen by a mode bit the host writes. With the bit clear, the pointer wraps at every 16 KiB boundary. With the bit set, it wraps at a programmable receive-region size.

Back-pressure rules:
- A command moves on a clock edge only when both `cmd_valid` and `cmd_ready` are high.
- A read or peek is not accepted while a response is still held and `rsp_ready` is low.
- A held response keeps its data until `rsp_ready` takes it.

Top module: `hbm_port`

## Requirements
- R1: After reset the read pointer is 0x0000, the write pointer is 0x0000, the mode bit is 0 and the region size is 0x1F00. No response is valid, and `cmd_ready` stays low until the first prefetch has filled.
- R2: A read-advance command (op 5) returns the data at the current pointer, zero-extended, and then adds 1, 2 or 4 to the pointer for bus width code 0, 1 or 2 (code 3 acts as 2). In 8-bit mode the lane is the byte picked by pointer bits [1:0], little-endian. In 16-bit mode it is the halfword picked by bit 1. In 32-bit mode it is the whole word at the pointer with bits [1:0] ignored.
- R3: A peek command (op 6) returns the same data a read would, and the pointer is left unchanged.
- R4: Op 0 loads pointer bits [7:0] from `cmd_data[7:0]`, and op 1 loads pointer bits [15:8] from `cmd_data[7:0]`. The next read returns data for the new address.
- R5: With the mode bit 0, a read that would move the pointer to or past the next multiple of 0x4000 sets it to 0x0000 instead.
- R6: With the mode bit 1, a read that would move the pointer to a value at or above the region size sets it to 0x0000, with no overshoot carried.
- R7: Op 3 loads the mode bit from `cmd_data[0]`. Op 4 loads the region size from `cmd_data[15:0]`, which otherwise keeps its default of 0x1F00.
- R8: Op 2 loads the write pointer from `cmd_data[15:0]`. The write command (op 7) stores host data at the write pointer: `cmd_data[7:0]` into the addressed byte in 8-bit mode, `cmd_data[15:0]` into the addressed halfword in 16-bit mode, the whole word in 32-bit mode. The write pointer is unchanged afterwards.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds and no read or peek is accepted.
- R10: After a write or any pointer change, the prefetch is reloaded. A read that follows a write to the current location returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_width | input | 2 | Host width code: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code (see requirements) |
| cmd_data | input | 32 | Command operand or write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | 32 | Read data, zero-extended |
| sram_addr | output | 16 | SRAM byte address |
| sram_ren | output | 1 | SRAM read enable; data one cycle later |
| sram_wen | output | 1 | SRAM write enable |
| sram_be | output | 4 | SRAM byte enables for writes |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data |

## Verification
Reads are tried in all three widths at every byte offset. This separates a wrong lane choice from a wrong step size, because a shifted lane returns a neighbouring byte that the bench's own memory copy can tell apart.

Pointers placed just below a 16 KiB boundary, at the default region end, and at a small programmed region size with an odd overshoot show whether the wrap compares against the right limit and whether it clears the pointer rather than carrying the excess.

Repeated peeks, writes to the byte under the pointer, and a held response with a pending read test the pointer hold, the reload after a write, and back-pressure. These directed cases are followed by a seeded random mix of all commands and widths.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    OP_RA_LO   = 3'd0,
    OP_RA_HI   = 3'd1,
    OP_WA      = 3'd2,
    OP_MODE    = 3'd3,
    OP_RXSZ    = 3'd4,
    OP_RD_INC  = 3'd5,
    OP_RD_PEEK = 3'd6,
    OP_WR      = 3'd7
  } hbm_op_e;

  // width code to pointer step in bytes
  function automatic logic [2:0] step_of(input logic [1:0] bw);
    case (bw)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // pick the host lane out of a memory word, little-endian
  function automatic logic [WORD_W-1:0] lane_of(input logic [WORD_W-1:0] w,
                                                input logic [1:0] lo,
                                                input logic [1:0] bw);
    logic [WORD_W-1:0] sh;
    case (bw)
      2'd0: begin
        sh = w >> (8 * lo);
        return {24'h0, sh[7:0]};
      end
      2'd1: begin
        sh = w >> (16 * lo[1]);
        return {16'h0, sh[15:0]};
      end
      default: return w;
    endcase
  endfunction
endpackage

// File: rtl/hbm_ptr.sv
module hbm_ptr
  import hbm_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned FIX_LOG2 = 14,
  parameter logic [AW-1:0] RXSZ_RST = 16'h1F00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [2:0]    op,
  input  logic [AW-1:0] opnd,
  input  logic [2:0]    step,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr,
  output logic          mode
);
  localparam int unsigned HI_W = AW - 8;

  logic [AW-1:0] rx_size;
  logic [AW:0]   sum;
  logic          cross_fix, cross_rx;
  logic [AW-1:0] next_ptr;

  always_comb begin
    sum       = {1'b0, rd_ptr} + (AW+1)'(step);
    cross_fix = sum[AW:FIX_LOG2] != {1'b0, rd_ptr[AW-1:FIX_LOG2]};
    cross_rx  = sum >= {1'b0, rx_size};
    next_ptr  = (mode ? cross_rx : cross_fix) ? '0 : sum[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      mode    <= 1'b0;
      rx_size <= RXSZ_RST;
    end else if (acc) begin
      case (hbm_op_e'(op))
        OP_RA_LO:  rd_ptr[7:0]    <= opnd[7:0];
        OP_RA_HI:  rd_ptr[AW-1:8] <= opnd[HI_W-1:0];
        OP_WA:     wr_ptr         <= opnd;
        OP_MODE:   mode           <= opnd[0];
        OP_RXSZ:   rx_size        <= opnd;
        OP_RD_INC: rd_ptr         <= next_ptr;
        default: ;
      endcase
    end
  end

  // R3: a peek leaves the read pointer in place
  a_r3_peek_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_RD_PEEK) |=> $stable(rd_ptr));

  // R5: in fixed mode an advance stays inside its 16 KiB bank or clears
  a_r5_fixed_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_RD_INC && !mode) |=>
      (rd_ptr[AW-1:FIX_LOG2] == $past(rd_ptr[AW-1:FIX_LOG2])) || (rd_ptr == '0));

  // R6: in region mode an advance lands below the region size or at zero
  a_r6_region_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_RD_INC && mode) |=> (rd_ptr < rx_size) || (rd_ptr == '0));

  // R8: a data write does not move the write pointer
  a_r8_wr_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_WR) |=> $stable(wr_ptr));
endmodule

// File: rtl/hbm_prefetch.sv
module hbm_prefetch
  import hbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inval,
  input  logic [WORD_W-1:0] sram_rdata,
  output logic              sram_ren,
  output logic              buf_valid,
  output logic [WORD_W-1:0] buf_word
);
  logic fill_pend;

  assign sram_ren = !buf_valid && !fill_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      fill_pend <= 1'b0;
      buf_word  <= '0;
    end else begin
      fill_pend <= sram_ren;
      if (inval) begin
        buf_valid <= 1'b0;
      end else if (fill_pend) begin
        buf_valid <= 1'b1;
        buf_word  <= sram_rdata;
      end
    end
  end

  // R10: a dropped buffer is refilled two cycles later
  a_r10_refill: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_valid) |=> ##1 buf_valid);
endmodule

// File: rtl/hbm_wsteer.sv
module hbm_wsteer
  import hbm_pkg::*;
(
  input  logic [1:0]        bw,
  input  logic [1:0]        lo,
  input  logic [WORD_W-1:0] din,
  output logic [3:0]        be,
  output logic [WORD_W-1:0] dout
);
  always_comb begin
    case (bw)
      2'd0: begin
        be   = 4'b0001 << lo;
        dout = {4{din[7:0]}};
      end
      2'd1: begin
        be   = lo[1] ? 4'b1100 : 4'b0011;
        dout = {2{din[15:0]}};
      end
      default: begin
        be   = 4'b1111;
        dout = din;
      end
    endcase
  end
endmodule

// File: rtl/hbm_port.sv
module hbm_port
  import hbm_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned FIX_LOG2 = 14,
  parameter logic [AW-1:0] RXSZ_RST = 16'h1F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_width,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic [AW-1:0]     sram_addr,
  output logic              sram_ren,
  output logic              sram_wen,
  output logic [3:0]        sram_be,
  output logic [WORD_W-1:0] sram_wdata,
  input  logic [WORD_W-1:0] sram_rdata
);
  logic              is_read, acc, inval, buf_valid, mode;
  logic [AW-1:0]     rd_ptr, wr_ptr;
  logic [WORD_W-1:0] buf_word;

  assign is_read   = (cmd_op == OP_RD_INC) || (cmd_op == OP_RD_PEEK);
  assign cmd_ready = buf_valid && (!is_read || !rsp_valid || rsp_ready);
  assign acc       = cmd_valid && cmd_ready;
  assign inval     = acc && (cmd_op == OP_RA_LO || cmd_op == OP_RA_HI ||
                             is_read || cmd_op == OP_WR);
  assign sram_wen  = acc && (cmd_op == OP_WR);
  assign sram_addr = sram_wen ? wr_ptr : rd_ptr;

  hbm_ptr #(.AW(AW), .FIX_LOG2(FIX_LOG2), .RXSZ_RST(RXSZ_RST)) ptr_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .op(cmd_op),
    .opnd(cmd_data[AW-1:0]), .step(step_of(bus_width)),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .mode(mode)
  );

  hbm_prefetch pf_i (
    .clk(clk), .rst_n(rst_n), .inval(inval), .sram_rdata(sram_rdata),
    .sram_ren(sram_ren), .buf_valid(buf_valid), .buf_word(buf_word)
  );

  hbm_wsteer ws_i (
    .bw(bus_width), .lo(wr_ptr[1:0]), .din(cmd_data),
    .be(sram_be), .dout(sram_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc && is_read) begin
      rsp_valid <= 1'b1;
      rsp_data  <= lane_of(buf_word, rd_ptr[1:0], bus_width);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a held response keeps its data until taken
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10: prefetch reads and host writes never share the SRAM port
  a_r10_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_ren && sram_wen));

  // R1: nothing is answered before the first fill completes
  a_r1_no_early_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cmd_ready);

  // mode only ever moves by a host command
  a_r7_mode_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && cmd_op == OP_MODE) |=> $stable(mode));
endmodule

// File: tb/hbm_port_tb_top.sv
module hbm_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_width = 2'd2;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] cmd_data = 32'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [15:0] sram_addr;
  logic        sram_ren, sram_wen;
  logic [3:0]  sram_be;
  logic [31:0] sram_wdata;
  logic [31:0] sram_rdata;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [31:0] mem     [0:16383];
  logic [31:0] ref_mem [0:16383];
  logic [15:0] m_ptr, m_wa, m_rxsz;
  logic        m_mode;

  always #5 clk = ~clk;

  hbm_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_width(bus_width),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .sram_addr(sram_addr), .sram_ren(sram_ren),
    .sram_wen(sram_wen), .sram_be(sram_be), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata)
  );

  // synchronous single-port SRAM model
  always @(posedge clk) begin
    if (sram_wen) begin
      for (int b = 0; b < 4; b++)
        if (sram_be[b]) mem[sram_addr[15:2]][b*8 +: 8] <= sram_wdata[b*8 +: 8];
    end
    if (sram_ren) sram_rdata <= mem[sram_addr[15:2]];
  end

  function automatic logic [31:0] exp_lane(input logic [31:0] w, input logic [1:0] lo,
                                           input logic [1:0] bw);
    if (bw == 2'd0) return {24'h0, w[lo*8 +: 8]};
    if (bw == 2'd1) return {16'h0, w[lo[1]*16 +: 16]};
    return w;
  endfunction

  function automatic logic [15:0] exp_next(input logic [15:0] p, input logic [1:0] bw,
                                           input logic md, input logic [15:0] lim);
    int st, nv;
    st = (bw == 2'd0) ? 1 : (bw == 2'd1) ? 2 : 4;
    nv = int'(p) + st;
    if (md) return (nv >= int'(lim)) ? 16'h0 : 16'(nv);
    return ((int'(p) % 16384) + st >= 16384) ? 16'h0 : 16'(nv);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] d);
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    issue(3'd0, {24'h0, a[7:0]});
    issue(3'd1, {24'h0, a[15:8]});
    m_ptr = a;
  endtask

  task automatic set_bw(input logic [1:0] bw);
    @(negedge clk);
    bus_width = bw;
  endtask

  task automatic do_read(input logic inc, input string req);
    logic [31:0] e;
    e = exp_lane(ref_mem[m_ptr[15:2]], m_ptr[1:0], bus_width);
    issue(inc ? 3'd5 : 3'd6, 32'h0);
    @(negedge clk);
    check(rsp_valid && rsp_data == e, req, rsp_data, e);
    if (inc) m_ptr = exp_next(m_ptr, bus_width, m_mode, m_rxsz);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    issue(3'd2, {16'h0, a});
    m_wa = a;
    issue(3'd7, d);
    if (bus_width == 2'd0)      ref_mem[a[15:2]][a[1:0]*8 +: 8] = d[7:0];
    else if (bus_width == 2'd1) ref_mem[a[15:2]][a[1]*16 +: 16] = d[15:0];
    else                        ref_mem[a[15:2]] = d;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] held, e;
    int unsigned r;
    r = $urandom(32'd1234);
    for (int i = 0; i < 16384; i++) begin
      mem[i]     = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      ref_mem[i] = mem[i];
    end
    m_ptr = 16'h0; m_wa = 16'h0; m_rxsz = 16'h1F00; m_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: just out of reset, no response and not ready
    check(!rsp_valid, "R1", {31'h0, rsp_valid}, 32'h0);
    check(!cmd_ready, "R1", {31'h0, cmd_ready}, 32'h0);
    do_read(1'b0, "R1");                 // word at 0x0000
    // R2: every width at every offset
    for (int bw = 0; bw < 3; bw++) begin
      set_bw(2'(bw));
      set_ptr(16'h0120);
      for (int k = 0; k < 6; k++) do_read(1'b1, "R2");
    end
    // R3: peeks repeat, then an advance sees the same data
    set_bw(2'd0);
    set_ptr(16'h0203);
    do_read(1'b0, "R3");
    do_read(1'b0, "R3");
    do_read(1'b1, "R3");
    // R4: high/low byte loads
    set_bw(2'd2);
    set_ptr(16'hA5B4);
    do_read(1'b1, "R4");
    // R5: fixed boundary
    set_ptr(16'h3FFE);
    do_read(1'b1, "R5");
    check(m_ptr == 16'h0, "R5", {16'h0, m_ptr}, 32'h0);
    do_read(1'b1, "R5");                 // now reads 0x0000
    set_bw(2'd1);
    set_ptr(16'h7FFE);
    do_read(1'b1, "R5");
    do_read(1'b0, "R5");                 // pointer at 0x0000
    // R7/R6: default region end, then a small programmed region
    issue(3'd3, 32'h1); m_mode = 1'b1;
    set_bw(2'd0);
    set_ptr(16'h1EFE);
    do_read(1'b1, "R7");
    do_read(1'b1, "R7");
    check(m_ptr == 16'h0, "R7", {16'h0, m_ptr}, 32'h0);
    do_read(1'b0, "R7");
    issue(3'd4, 32'h0010); m_rxsz = 16'h0010;
    set_bw(2'd1);
    set_ptr(16'h000E);
    do_read(1'b1, "R6");
    do_read(1'b0, "R6");
    set_bw(2'd2);
    set_ptr(16'h000F);
    do_read(1'b1, "R6");
    do_read(1'b0, "R6");                 // overshoot not carried: at 0x0000
    issue(3'd3, 32'h0); m_mode = 1'b0;
    // R8: two byte writes to one address, neighbour untouched
    set_bw(2'd0);
    do_write(16'h0101, 32'h000000AB);
    do_write(16'h0101, 32'h000000CD);
    set_ptr(16'h0101);
    do_read(1'b1, "R8");
    set_ptr(16'h0100);
    do_read(1'b1, "R8");
    set_bw(2'd1);
    do_write(16'h0302, 32'h0000BEEF);
    set_ptr(16'h0300);
    set_bw(2'd2);
    do_read(1'b0, "R8");
    // R10: write under the pointer, then peek sees new data
    set_ptr(16'h0400);
    do_read(1'b0, "R10");
    do_write(16'h0400, 32'hC0FFEE11);
    do_read(1'b0, "R10");
    // R9: held response blocks the next read
    set_ptr(16'h0500);
    rsp_ready = 1'b0;
    e = exp_lane(ref_mem[m_ptr[15:2]], m_ptr[1:0], bus_width);
    issue(3'd6, 32'h0);
    @(negedge clk);
    held = rsp_data;
    check(rsp_valid && held == e, "R9", held, e);
    cmd_op = 3'd5; cmd_data = 32'h0; cmd_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!cmd_ready, "R9", {31'h0, cmd_ready}, 32'h0);
      check(rsp_valid && rsp_data == held, "R9", rsp_data, held);
    end
    rsp_ready = 1'b1;
    #1 check(cmd_ready, "R9", {31'h0, cmd_ready}, 32'h1);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid && rsp_data == e, "R9", rsp_data, e);
    m_ptr = exp_next(m_ptr, bus_width, m_mode, m_rxsz);
    // constrained random mix
    for (int n = 0; n < 500; n++) begin
      r = $urandom % 100;
      if (r < 40)       do_read(1'b1, "R2");
      else if (r < 55)  do_read(1'b0, "R3");
      else if (r < 65)  set_ptr(16'($urandom));
      else if (r < 78)  do_write(16'($urandom), $urandom);
      else if (r < 88)  set_bw(2'($urandom % 4));
      else if (r < 94) begin
        m_mode = 1'($urandom);
        issue(3'd3, {31'h0, m_mode});
      end else begin
        m_rxsz = 16'h0100 + 16'($urandom % 16'h3F00);
        issue(3'd4, {16'h0, m_rxsz});
      end
    end
    finish_run();
  end
endmodule